// File: doc/BRIEF.md
# Lightning Event Interrupt Manager

This block sits between the lightning classification logic and the host interface of a storm sensor. It takes single-cycle pulses announcing a confirmed lightning strike, a rejected man-made disturber and a distance update caused only by old events ageing out. It also takes a level input that is high while the noise floor is above its limit. From these it keeps a 4-bit interrupt cause code and drives an active-high interrupt line. The line stays high until the host reads the interrupt register.

Lightning interrupts are qualified by storm statistics. The block keeps a sliding window of recent strikes: 15 one-minute bins advanced by a slow minute tick, and the window count is the sum of the bins. A strike raises an interrupt only once the window holds at least the selected minimum number of strikes. Disturber interrupts can be masked. The statistics are wiped when the host drives a control bit high, then low, then high again. A purge-only distance change raises the line with an all-zero cause code.

Top module: `lightning_irq_mgr`

## Requirements
- R1: A qualifying strike pulse sets `irq` high at the next clock edge, and `int_code` then reads 4'b1000.
- R2: A pulse on `int_read` with no event in the same cycle drives `irq` low at the next clock edge. `int_code` is left unchanged.
- R3: A rising edge of `noise_high` sets `irq` and stores cause 4'b0001. While `noise_high` stays high, `int_code` shows 4'b0001 whatever other events arrive. Once it falls, `int_code` shows the most recently stored cause.
- R4: With `mask_disturber` = 0, a disturber pulse sets `irq` and stores 4'b0100. With `mask_disturber` = 1, a disturber pulse leaves both `irq` and `int_code` unchanged.
- R5: `min_strike_sel` picks the minimum window count: 2'b00 = 1, 2'b01 = 5, 2'b10 = 9, 2'b11 = 16. A strike qualifies when the window count including that strike reaches this minimum. A non-qualifying strike is still counted but leaves `irq` and `int_code` unchanged.
- R6: A purge pulse sets `irq` and stores cause 4'b0000.
- R7: The window is cleared in the cycle where `clear_stats` is seen high after having been seen high and then low. The pattern high then low alone clears nothing.
- R8: Each strike adds one to `strike_count` at the next edge. A strike stays counted through 14 minute ticks and is dropped at the 15th tick after it.
- R9: `strike_count` saturates at 31 and never wraps.
- R10: When several causes arrive before a read, `int_code` holds the latest one and `irq` stays high until the read. Within one cycle the priority is lightning, then disturber, then noise, then purge.
- R11: After reset, `irq` = 0, `int_code` = 4'b0000 and `strike_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strike_pulse | input | 1 | One-cycle pulse: lightning confirmed |
| disturber_pulse | input | 1 | One-cycle pulse: disturber rejected |
| purge_pulse | input | 1 | One-cycle pulse: distance changed by ageing only |
| noise_high | input | 1 | Level: noise above threshold |
| mask_disturber | input | 1 | 1 = disturber events raise no interrupt |
| min_strike_sel | input | 2 | Minimum window count select |
| clear_stats | input | 1 | Statistics clear control bit (high-low-high) |
| minute_tick | input | 1 | One-cycle pulse per minute |
| int_read | input | 1 | One-cycle pulse: host reads interrupt register |
| irq | output | 1 | Active-high interrupt |
| int_code | output | 4 | Interrupt cause code |
| strike_count | output | 5 | Strikes in the 15-minute window |

## Verification
The bench walks each minimum-count setting to its exact boundary. A design that compared against the count before the new strike would fire one strike late, and one that decoded the select wrongly would fire at the wrong strike. It ticks the window 14 and then 15 times after a burst, so an off-by-one bin rotation shows up as a count that drops one minute early or late. It drives only the first two phases of the clear pattern, which catches a clear that fires on a single edge. It also checks that a masked disturber leaves the stored code alone, that the noise code overrides other causes while noise lasts, and that the count sticks at 31.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam logic [3:0] CAUSE_PURGE     = 4'b0000;
  localparam logic [3:0] CAUSE_NOISE     = 4'b0001;
  localparam logic [3:0] CAUSE_DISTURBER = 4'b0100;
  localparam logic [3:0] CAUSE_LIGHTNING = 4'b1000;

  typedef enum logic [1:0] {
    CLR_WAIT_HI  = 2'd0,
    CLR_WAIT_LO  = 2'd1,
    CLR_WAIT_HI2 = 2'd2
  } clr_state_e;

  // Minimum strike count selected by the two-bit field.
  function automatic logic [4:0] min_strikes(input logic [1:0] sel);
    case (sel)
      2'b00:   min_strikes = 5'd1;
      2'b01:   min_strikes = 5'd5;
      2'b10:   min_strikes = 5'd9;
      default: min_strikes = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/lim_reset_sync.sv
module lim_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lim_clear_detect.sv
module lim_clear_detect
  import lim_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_bit,
  output logic clr_pulse
);
  clr_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    clr_pulse = 1'b0;
    case (state_q)
      CLR_WAIT_HI:  if (ctrl_bit)  state_d = CLR_WAIT_LO;
      CLR_WAIT_LO:  if (!ctrl_bit) state_d = CLR_WAIT_HI2;
      CLR_WAIT_HI2: if (ctrl_bit) begin
        clr_pulse = 1'b1;
        state_d   = CLR_WAIT_LO;
      end
      default:      state_d = CLR_WAIT_HI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CLR_WAIT_HI;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/lim_strike_window.sv
module lim_strike_window #(
  parameter int NBINS = 15,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strike,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = $clog2(NBINS);
  localparam int SUM_W = CNT_W + $clog2(NBINS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PTR_W-1:0] LAST    = PTR_W'(NBINS - 1);

  logic [CNT_W-1:0] bin_q [NBINS];
  logic [CNT_W-1:0] bin_d [NBINS];
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [SUM_W-1:0] sum;

  always_comb begin
    ptr_d = ptr_q;
    for (int i = 0; i < NBINS; i++) bin_d[i] = bin_q[i];
    if (clr) begin
      for (int i = 0; i < NBINS; i++) bin_d[i] = '0;
    end else begin
      if (tick) begin
        ptr_d        = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
        bin_d[ptr_d] = '0;
      end
      if (strike && (bin_d[ptr_d] != CNT_MAX))
        bin_d[ptr_d] = bin_d[ptr_d] + CNT_W'(1);
    end
  end

  generate
    for (genvar g = 0; g < NBINS; g++) begin : g_bin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bin_q[g] <= '0;
        else        bin_q[g] <= bin_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NBINS; i++) sum = sum + SUM_W'(bin_q[i]);
  end

  assign count = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
endmodule

// File: rtl/lim_cause_reg.sv
module lim_cause_reg
  import lim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       light_evt,
  input  logic       dist_evt,
  input  logic       noise_evt,
  input  logic       purge_evt,
  input  logic       noise_high,
  input  logic       int_read,
  output logic       irq,
  output logic [3:0] int_code
);
  logic       irq_q, irq_d;
  logic [3:0] code_q, code_d;
  logic       any_evt;

  assign any_evt = light_evt | dist_evt | noise_evt | purge_evt;

  always_comb begin
    code_d = code_q;
    if      (light_evt) code_d = CAUSE_LIGHTNING;
    else if (dist_evt)  code_d = CAUSE_DISTURBER;
    else if (noise_evt) code_d = CAUSE_NOISE;
    else if (purge_evt) code_d = CAUSE_PURGE;

    irq_d = irq_q;
    if (any_evt)       irq_d = 1'b1;
    else if (int_read) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      code_q <= CAUSE_PURGE;
    end else begin
      irq_q  <= irq_d;
      code_q <= code_d;
    end
  end

  assign irq      = irq_q;
  assign int_code = noise_high ? CAUSE_NOISE : code_q;
endmodule

// File: rtl/lightning_irq_mgr.sv
module lightning_irq_mgr
  import lim_pkg::*;
#(
  parameter int NBINS = 15,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strike_pulse,
  input  logic             disturber_pulse,
  input  logic             purge_pulse,
  input  logic             noise_high,
  input  logic             mask_disturber,
  input  logic [1:0]       min_strike_sel,
  input  logic             clear_stats,
  input  logic             minute_tick,
  input  logic             int_read,
  output logic             irq,
  output logic [3:0]       int_code,
  output logic [CNT_W-1:0] strike_count
);
  logic             rst_n_sync;
  logic             clr_pulse;
  logic             noise_q;
  logic             noise_rise;
  logic             light_ok;
  logic             dist_ok;
  logic [CNT_W:0]   count_next;

  lim_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lim_clear_detect u_clr (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .ctrl_bit  (clear_stats),
    .clr_pulse (clr_pulse)
  );

  lim_strike_window #(.NBINS(NBINS), .CNT_W(CNT_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .strike (strike_pulse),
    .tick   (minute_tick),
    .clr    (clr_pulse),
    .count  (strike_count)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) noise_q <= 1'b0;
    else             noise_q <= noise_high;
  end

  assign noise_rise = noise_high & ~noise_q;
  assign count_next = {1'b0, strike_count} + (CNT_W+1)'(1);
  assign light_ok   = strike_pulse &&
                      (count_next >= (CNT_W+1)'(min_strikes(min_strike_sel)));
  assign dist_ok    = disturber_pulse & ~mask_disturber;

  lim_cause_reg u_cause (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .light_evt  (light_ok),
    .dist_evt   (dist_ok),
    .noise_evt  (noise_rise),
    .purge_evt  (purge_pulse),
    .noise_high (noise_high),
    .int_read   (int_read),
    .irq        (irq),
    .int_code   (int_code)
  );
endmodule

// File: rtl/lim_checker.sv
module lim_checker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strike_pulse,
  input logic             disturber_pulse,
  input logic             purge_pulse,
  input logic             noise_rise,
  input logic             mask_disturber,
  input logic             minute_tick,
  input logic             clr_pulse,
  input logic             int_read,
  input logic             irq,
  input logic [3:0]       int_code,
  input logic [CNT_W-1:0] strike_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int_read && !strike_pulse && !disturber_pulse && !purge_pulse && !noise_rise)
    |=> !irq);

  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_disturber && disturber_pulse && !strike_pulse && !purge_pulse &&
     !noise_rise && !irq) |=> !irq);

  assert_noise_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    noise_rise |=> irq);

  assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (int_code == 4'b0000 || int_code == 4'b0001 ||
                    int_code == 4'b0100 || int_code == 4'b1000));

  assert_strike_adds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strike_pulse && !minute_tick && !clr_pulse && strike_count != CNT_MAX)
    |=> strike_count == $past(strike_count) + CNT_W'(1));

  assert_no_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!minute_tick && !clr_pulse) |=> strike_count >= $past(strike_count));
endmodule

bind lightning_irq_mgr lim_checker #(.CNT_W(CNT_W)) u_lim_chk (
  .clk             (clk),
  .rst_n           (rst_n_sync),
  .strike_pulse    (strike_pulse),
  .disturber_pulse (disturber_pulse),
  .purge_pulse     (purge_pulse),
  .noise_rise      (noise_rise),
  .mask_disturber  (mask_disturber),
  .minute_tick     (minute_tick),
  .clr_pulse       (clr_pulse),
  .int_read        (int_read),
  .irq             (irq),
  .int_code        (int_code),
  .strike_count    (strike_count)
);

// File: tb/lightning_irq_mgr_bench.sv
module lightning_irq_mgr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strike_pulse = 1'b0, disturber_pulse = 1'b0, purge_pulse = 1'b0;
  logic       noise_high = 1'b0, mask_disturber = 1'b0, clear_stats = 1'b0;
  logic       minute_tick = 1'b0, int_read = 1'b0;
  logic [1:0] min_strike_sel = 2'b00;
  logic       irq;
  logic [3:0] int_code;
  logic [4:0] strike_count;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  lightning_irq_mgr u_lightning_irq_mgr (
    .clk, .rst_n, .strike_pulse, .disturber_pulse, .purge_pulse, .noise_high,
    .mask_disturber, .min_strike_sel, .clear_stats, .minute_tick, .int_read,
    .irq, .int_code, .strike_count
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic do_read();
    pulse(int_read);
  endtask

  task automatic do_clear();
    @(negedge clk); clear_stats = 1'b1; idle(2);
    clear_stats = 1'b0; idle(2);
    clear_stats = 1'b1; idle(2);
  endtask

  task automatic t_reset();
    check("R11 irq", irq, 0);
    check("R11 code", int_code, 0);
    check("R11 count", strike_count, 0);
  endtask

  task automatic t_lightning();
    pulse(strike_pulse);
    check("R1 irq", irq, 1);
    check("R1 code", int_code, 8);
    check("R8 count", strike_count, 1);
    do_read();
    check("R2 irq low", irq, 0);
    check("R2 code kept", int_code, 8);
  endtask

  task automatic t_disturber();
    mask_disturber = 1'b0;
    pulse(disturber_pulse);
    check("R4 irq", irq, 1);
    check("R4 code", int_code, 4);
    do_read();
    mask_disturber = 1'b1;
    pulse(purge_pulse); do_read();
    check("R6 code before masked", int_code, 0);
    pulse(disturber_pulse);
    check("R4 masked irq", irq, 0);
    check("R4 masked code", int_code, 0);
    mask_disturber = 1'b0;
  endtask

  task automatic t_noise();
    @(negedge clk); noise_high = 1'b1;
    @(negedge clk);
    check("R3 irq", irq, 1);
    check("R3 code", int_code, 1);
    pulse(disturber_pulse);
    check("R3 code held", int_code, 1);
    do_read();
    check("R3 read irq", irq, 0);
    check("R3 code still", int_code, 1);
    @(negedge clk); noise_high = 1'b0;
    @(negedge clk);
    check("R3 stored code", int_code, 4);
  endtask

  task automatic t_purge();
    pulse(purge_pulse);
    check("R6 irq", irq, 1);
    check("R6 code", int_code, 0);
    do_read();
  endtask

  task automatic t_recent();
    pulse(disturber_pulse);
    pulse(strike_pulse);
    check("R10 code", int_code, 8);
    check("R10 irq", irq, 1);
    pulse(purge_pulse);
    check("R10 latest", int_code, 0);
    check("R10 irq held", irq, 1);
    do_read();
    check("R10 read", irq, 0);
  endtask

  task automatic t_clear();
    check("R7 count before", strike_count, 2);
    @(negedge clk); clear_stats = 1'b1; idle(2);
    clear_stats = 1'b0; idle(2);
    check("R7 partial", strike_count, 2);
    clear_stats = 1'b1; idle(2);
    check("R7 cleared", strike_count, 0);
  endtask

  task automatic t_threshold(logic [1:0] sel, int need);
    do_clear();
    min_strike_sel = sel;
    pulse(purge_pulse); do_read();
    for (int i = 1; i < need; i++) pulse(strike_pulse);
    check("R5 below irq", irq, 0);
    check("R5 below code", int_code, 0);
    check("R5 below count", strike_count, need - 1);
    pulse(strike_pulse);
    check("R5 at irq", irq, 1);
    check("R5 at code", int_code, 8);
    do_read();
  endtask

  task automatic t_window();
    min_strike_sel = 2'b00;
    do_clear();
    repeat (3) pulse(strike_pulse);
    do_read();
    repeat (14) pulse(minute_tick);
    check("R8 after 14", strike_count, 3);
    pulse(strike_pulse);
    check("R8 new minute", strike_count, 4);
    pulse(minute_tick);
    check("R8 after 15", strike_count, 1);
    do_read();
  endtask

  task automatic t_saturate();
    do_clear();
    repeat (40) pulse(strike_pulse);
    check("R9 sat", strike_count, 31);
    do_read();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_lightning();
    t_disturber();
    t_noise();
    t_purge();
    t_recent();
    t_clear();
    t_threshold(2'b01, 5);
    t_threshold(2'b10, 9);
    t_threshold(2'b11, 16);
    t_window();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule